// File: doc/BRIEF.md
# Link Negotiation Timing Sequencer

The sequencer steps through the timed phases that an Ethernet PHY goes through before it declares a link up. The far-end partner either can or cannot negotiate, and that choice selects one of two fixed chains. Both chains open with a break-link phase. A partner that cannot negotiate is followed by a wait phase. A partner that can negotiate is followed by a shorter burst-exchange phase. Both chains then close with a link-fail-inhibit phase. When the inhibit phase ends, the link comes up if the link-ready input is high. If it is low, the block raises a one-cycle timeout pulse and starts the chain again at break link.

Phase lengths are given in milliseconds. Each length is first clamped into its legal window, and the window is fixed inside the block. The clamped value is then converted into a count of tick-enable pulses using a scaling parameter. With a coarse scale a whole negotiation cycle takes a few dozen ticks in simulation, while the real-time ratios between phases are kept. A start pulse may arrive at any time. It aborts whatever the block is doing and begins a fresh cycle.

Top module: `link_neg_seq`

## Requirements
- R1: While reset is held, and after it is released, `phase_o` is 0 (idle), and `link_up_o` and `timeout_o` are both 0.
- R2: In idle the phase stays 0 until `start_i` is seen. Ticks and the other inputs have no effect there.
- R3: A high `start_i` at a clock edge moves the block, in any phase, to break link (`phase_o` = 1) at that edge. It restarts the phase count and clears `link_up_o`.
- R4: Break link lasts its tick count. At its last tick the block goes to wait (`phase_o` = 2) if `partner_neg_i` is 0, or to burst exchange (`phase_o` = 3) if it is 1.
- R5: Wait and burst exchange each last their own tick count and then go to link-fail inhibit (`phase_o` = 4).
- R6: At the last tick of inhibit, if `link_ready_i` is 1, the block goes to up (`phase_o` = 5). From that edge on, `link_up_o` is 1 and it stays 1 exactly while the phase is up.
- R7: At the last tick of inhibit, if `link_ready_i` is 0, the block goes back to break link. `timeout_o` is 1 for exactly that one cycle.
- R8: Up holds until the next `start_i`. A later drop of `link_ready_i` has no effect.
- R9: A phase advances only on clock edges where `tick_i` is 1. Cycles without a tick leave the phase and its progress unchanged.
- R10: Each phase length in ticks is its millisecond parameter, clamped to the window (break 1200..1500, wait 500..1000, burst 104..312, inhibit 750..1000), divided by `MS_PER_TICK` and rounded up, with a minimum of 1. With the defaults (100 ms per tick), start-to-up takes 13+8+8 = 29 ticks for a partner that cannot negotiate and 13+2+8 = 23 ticks for one that can.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base enable; one pulse is one time unit |
| start_i | input | 1 | Start or restart a negotiation cycle |
| partner_neg_i | input | 1 | Far-end partner can negotiate |
| link_ready_i | input | 1 | Link is ready when inhibit ends |
| phase_o | output | 3 | Current phase: 0 idle, 1 break, 2 wait, 3 burst, 4 inhibit, 5 up |
| link_up_o | output | 1 | Link declared up |
| timeout_o | output | 1 | One-cycle pulse when inhibit ends without a ready link |

## Verification
Some rules are checked by assertions on every cycle:
- restart always lands in break link;
- wait is entered only from break link with a non-negotiating partner;
- the timeout pulse lasts a single cycle and coincides with break link;
- link-up tracks the up phase;
- idle and up hold without a start;
- the phase counter stays below its limit and does not move without a tick.

Other behaviour only the bench's scenarios can show:
- the exact tick totals of each path;
- that break link samples the partner flag at its last tick;
- that a restart in the middle of a phase resets progress;
- that the timeout path leads to a later successful link.

A cycle-accurate model in the bench covers all of these.

// File: rtl/lns_pkg.sv
package lns_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_BREAK = 3'd1,
        PH_WAIT  = 3'd2,
        PH_BURST = 3'd3,
        PH_INHIB = 3'd4,
        PH_UP    = 3'd5
    } phase_e;

    // Legal windows of each phase in milliseconds.
    localparam int BREAK_LO_MS = 1200;
    localparam int BREAK_HI_MS = 1500;
    localparam int WAIT_LO_MS  = 500;
    localparam int WAIT_HI_MS  = 1000;
    localparam int BURST_LO_MS = 104;
    localparam int BURST_HI_MS = 312;
    localparam int INHIB_LO_MS = 750;
    localparam int INHIB_HI_MS = 1000;

    // Clamp a length into its window and turn it into whole ticks (rounded up).
    function automatic int ms_to_ticks(int ms, int lo, int hi, int ms_per_tick);
        int c;
        int m;
        int t;
        m = (ms_per_tick < 1) ? 1 : ms_per_tick;
        c = (ms < lo) ? lo : ((ms > hi) ? hi : ms);
        t = (c + m - 1) / m;
        return (t < 1) ? 1 : t;
    endfunction

    function automatic int max_of4(int a, int b, int c, int d);
        int r;
        r = a;
        if (b > r) r = b;
        if (c > r) r = c;
        if (d > r) r = d;
        return r;
    endfunction

endpackage

// File: rtl/lns_dur_pick.sv
module lns_dur_pick
    import lns_pkg::*;
#(
    parameter int CW      = 4,
    parameter int BREAK_T = 13,
    parameter int WAIT_T  = 8,
    parameter int BURST_T = 2,
    parameter int INHIB_T = 8
) (
    input  phase_e          phase_i,
    output logic [CW-1:0]   limit_o
);

    localparam logic [CW-1:0] L_BREAK = CW'(BREAK_T);
    localparam logic [CW-1:0] L_WAIT  = CW'(WAIT_T);
    localparam logic [CW-1:0] L_BURST = CW'(BURST_T);
    localparam logic [CW-1:0] L_INHIB = CW'(INHIB_T);

    always_comb begin
        case (phase_i)
            PH_WAIT:  limit_o = L_WAIT;
            PH_BURST: limit_o = L_BURST;
            PH_INHIB: limit_o = L_INHIB;
            default:  limit_o = L_BREAK;
        endcase
    end

endmodule

// File: rtl/lns_tick_count.sv
module lns_tick_count #(
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          done_o
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == (limit_i - CW'(1)));
    assign done_o  = run_i && tick_i && at_last && !clr_i;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || !run_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = at_last ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R10: the position inside a running phase never reaches its length
    a_r10_cnt_below_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q < limit_i));

    // R9: without a tick a running phase keeps its progress
    a_r9_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !tick_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/lns_phase_ctl.sv
module lns_phase_ctl
    import lns_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   start_i,
    input  logic   partner_i,
    input  logic   ready_i,
    input  logic   done_i,
    output phase_e phase_o,
    output logic   up_o,
    output logic   tmo_o
);

    typedef struct packed {
        phase_e phase;
        logic   up;
        logic   tmo;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tmo = 1'b0;
        if (start_i) begin
            st_d.phase = PH_BREAK;
            st_d.up    = 1'b0;
        end else if (done_i) begin
            case (st_q.phase)
                PH_BREAK: st_d.phase = partner_i ? PH_BURST : PH_WAIT;
                PH_WAIT,
                PH_BURST: st_d.phase = PH_INHIB;
                PH_INHIB: begin
                    if (ready_i) begin
                        st_d.phase = PH_UP;
                        st_d.up    = 1'b1;
                    end else begin
                        st_d.phase = PH_BREAK;
                        st_d.tmo   = 1'b1;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= PH_IDLE;
            st_q.up    <= 1'b0;
            st_q.tmo   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign up_o    = st_q.up;
    assign tmo_o   = st_q.tmo;

    a_r3_restart_to_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (st_q.phase == PH_BREAK && !st_q.up));

    a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_IDLE && !start_i) |=> (st_q.phase == PH_IDLE));

    a_r8_up_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_UP && !start_i) |=> (st_q.phase == PH_UP && st_q.up));

    a_r6_up_flag_tracks_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.up == (st_q.phase == PH_UP));

    a_r7_timeout_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.tmo |=> !st_q.tmo);

    a_r7_timeout_in_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.tmo |-> (st_q.phase == PH_BREAK));

    a_r4_wait_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_WAIT && $past(st_q.phase) != PH_WAIT)
        |-> ($past(st_q.phase) == PH_BREAK && !$past(partner_i)));

    a_r1_phase_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.phase <= PH_UP);

endmodule

// File: rtl/link_neg_seq.sv
module link_neg_seq
    import lns_pkg::*;
#(
    parameter int MS_PER_TICK = 100,
    parameter int BREAK_MS    = 1300,
    parameter int WAIT_MS     = 750,
    parameter int BURST_MS    = 200,
    parameter int INHIBIT_MS  = 800
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       start_i,
    input  logic       partner_neg_i,
    input  logic       link_ready_i,
    output logic [2:0] phase_o,
    output logic       link_up_o,
    output logic       timeout_o
);

    localparam int BREAK_T = ms_to_ticks(BREAK_MS,   BREAK_LO_MS, BREAK_HI_MS, MS_PER_TICK);
    localparam int WAIT_T  = ms_to_ticks(WAIT_MS,    WAIT_LO_MS,  WAIT_HI_MS,  MS_PER_TICK);
    localparam int BURST_T = ms_to_ticks(BURST_MS,   BURST_LO_MS, BURST_HI_MS, MS_PER_TICK);
    localparam int INHIB_T = ms_to_ticks(INHIBIT_MS, INHIB_LO_MS, INHIB_HI_MS, MS_PER_TICK);
    localparam int MAX_T   = max_of4(BREAK_T, WAIT_T, BURST_T, INHIB_T);
    localparam int CW      = (MAX_T < 2) ? 1 : $clog2(MAX_T + 1);

    phase_e        phase_w;
    logic [CW-1:0] limit_w;
    logic          run_w;
    logic          done_w;

    assign run_w = (phase_w == PH_BREAK) || (phase_w == PH_WAIT) ||
                   (phase_w == PH_BURST) || (phase_w == PH_INHIB);

    lns_dur_pick #(
        .CW      (CW),
        .BREAK_T (BREAK_T),
        .WAIT_T  (WAIT_T),
        .BURST_T (BURST_T),
        .INHIB_T (INHIB_T)
    ) i_dur (
        .phase_i (phase_w),
        .limit_o (limit_w)
    );

    lns_tick_count #(
        .CW (CW)
    ) i_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (start_i),
        .run_i   (run_w),
        .tick_i  (tick_i),
        .limit_i (limit_w),
        .done_o  (done_w)
    );

    lns_phase_ctl i_ctl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .partner_i (partner_neg_i),
        .ready_i   (link_ready_i),
        .done_i    (done_w),
        .phase_o   (phase_w),
        .up_o      (link_up_o),
        .tmo_o     (timeout_o)
    );

    assign phase_o = phase_w;

    // R5: burst and wait always hand over to inhibit, never straight to up
    a_r5_no_skip_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_w == PH_UP && $past(phase_w) != PH_UP) |-> ($past(phase_w) == PH_INHIB));

endmodule

// File: tb/test_link_neg_seq.sv
module test_link_neg_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       start = 1'b0;
    logic       partner = 1'b0;
    logic       ready = 1'b0;
    logic [2:0] phase;
    logic       link_up;
    logic       timeout;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int tick_period = 1;
    bit tick_on = 1'b0;
    int tick_used = 0;
    int ph_seen = 0;
    bit done_flag = 1'b0;

    // expected lengths in ticks: ceil(ms / 100)
    localparam int D_BRK = (1300 + 99) / 100;
    localparam int D_WAI = (750 + 99) / 100;
    localparam int D_BUR = (200 + 99) / 100;
    localparam int D_INH = (800 + 99) / 100;

    // reference model state
    int m_ph = 0;
    int m_cnt = 0;
    bit m_up = 1'b0;
    bit m_tmo = 1'b0;

    always #4 clk = ~clk;

    link_neg_seq i_link_neg_seq (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .tick_i        (tick),
        .start_i       (start),
        .partner_neg_i (partner),
        .link_ready_i  (ready),
        .phase_o       (phase),
        .link_up_o     (link_up),
        .timeout_o     (timeout)
    );

    function automatic int dur_of(int p);
        case (p)
            1: return D_BRK;
            2: return D_WAI;
            3: return D_BUR;
            default: return D_INH;
        endcase
    endfunction

    function automatic string tag_of(int p);
        case (p)
            0: return "R2";
            1: return "R4";
            2, 3: return "R5";
            4: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // behavioural model, advanced on every edge
    always @(posedge clk) begin
        if (tick && ph_seen >= 1 && ph_seen <= 4 && !start) tick_used++;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_up = 1'b0; m_tmo = 1'b0;
        end else begin
            m_tmo = 1'b0;
            if (start) begin
                m_ph = 1; m_cnt = 0; m_up = 1'b0;
            end else if (tick && m_ph >= 1 && m_ph <= 4) begin
                m_cnt++;
                if (m_cnt >= dur_of(m_ph)) begin
                    m_cnt = 0;
                    if (m_ph == 1) m_ph = partner ? 3 : 2;
                    else if (m_ph == 2 || m_ph == 3) m_ph = 4;
                    else if (ready) begin m_ph = 5; m_up = 1'b1; end
                    else begin m_ph = 1; m_tmo = 1'b1; end
                end
            end
        end
    end

    // compare and drive the tick, away from the active edge
    always @(negedge clk) begin
        cyc++;
        ph_seen = int'(phase);
        if (rst_n) begin
            chk(int'(phase) == m_ph, tag_of(m_ph), int'(phase), m_ph);
            chk(link_up == m_up, "R6", int'(link_up), int'(m_up));
            chk(timeout == m_tmo, "R7", int'(timeout), int'(m_tmo));
        end
        tick <= tick_on && ((cyc % tick_period) == 0);
        if (cyc > 100000 && !done_flag) begin
            done_flag = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start <= 1'b1;
        tick_used = 0;
        @(negedge clk);
        start <= 1'b0;
    endtask

    task automatic wait_phase(input int p);
        for (int i = 0; i < 2000 && int'(phase) != p; i++) @(negedge clk);
    endtask

    initial begin
        cycles(4);
        chk(phase == 3'd0 && !link_up && !timeout, "R1", int'(phase), 0);
        rst_n <= 1'b1;
        cycles(2);
        chk(phase == 3'd0, "R1", int'(phase), 0);

        // R2: ticks in idle do nothing
        tick_on = 1'b1; tick_period = 1; ready <= 1'b1;
        cycles(12);
        chk(phase == 3'd0 && !link_up, "R2", int'(phase), 0);

        // non-negotiating partner, R10 total
        partner <= 1'b0;
        pulse_start();
        chk(phase == 3'd1, "R3", int'(phase), 1);
        wait_phase(5);
        cycles(1);
        chk(tick_used == D_BRK + D_WAI + D_INH, "R10", tick_used, D_BRK + D_WAI + D_INH);
        chk(link_up == 1'b1, "R6", int'(link_up), 1);

        // R8: ready drop ignored in up
        ready <= 1'b0;
        cycles(15);
        chk(phase == 3'd5 && link_up, "R8", int'(phase), 5);

        // negotiating partner, sparse ticks
        ready <= 1'b1; partner <= 1'b1; tick_period = 3;
        pulse_start();
        wait_phase(5);
        cycles(1);
        chk(tick_used == D_BRK + D_BUR + D_INH, "R10", tick_used, D_BRK + D_BUR + D_INH);

        // R7: timeout path then recovery
        ready <= 1'b0; tick_period = 1;
        pulse_start();
        for (int i = 0; i < 2000 && !timeout; i++) @(negedge clk);
        chk(timeout == 1'b1 && phase == 3'd1, "R7", int'(phase), 1);
        cycles(1);
        chk(timeout == 1'b0, "R7", int'(timeout), 0);
        ready <= 1'b1;
        wait_phase(3);
        chk(phase == 3'd3, "R4", int'(phase), 3);
        wait_phase(5);
        chk(link_up == 1'b1, "R6", int'(link_up), 1);

        // R3: restart from the middle of wait and from up
        partner <= 1'b0;
        pulse_start();
        wait_phase(2);
        chk(phase == 3'd2, "R4", int'(phase), 2);
        cycles(3);
        pulse_start();
        chk(phase == 3'd1 && !link_up, "R3", int'(phase), 1);
        wait_phase(5);
        pulse_start();
        chk(phase == 3'd1 && !link_up, "R3", int'(link_up), 0);

        // R9: no ticks, no progress
        cycles(3);
        tick_on = 1'b0;
        cycles(25);
        chk(phase == 3'd1, "R9", int'(phase), 1);
        tick_on = 1'b1;
        wait_phase(4);
        chk(phase == 3'd4, "R5", int'(phase), 4);
        wait_phase(5);
        cycles(2);

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule